// File: doc/BRIEF.md
# Ring Signal Qualification Integrator

This block decides whether a power-ring burst is present on a telephone line. Its only signal input is the digital output of a comparator that sits high while the attenuated ring waveform is above a fixed analog level. The block resynchronises that input and samples it on a slow tick, nominally 800 Hz, divided down from the system clock. On each tick a saturating up/down counter moves one step toward the sampled level.

Once the count has climbed to the qualification level (48 by default), a registered active-low ring-detect output is driven low. It can be used directly as a microcontroller interrupt. The output returns high as soon as the count falls below that level. Brief bursts and noise cancel out in the count, while a sustained ring with a mostly-high duty cycle accumulates.

A synchronous enable holds the whole function idle when low.

Top module: `ring_qual_top`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `ring_det_n` is 1 and the integrator count is 0. After reset, 48 net up-ticks are needed before `ring_det_n` goes low.
- R2: A sample tick occurs once every `TICK_DIV` clock cycles while `en` is high. The count changes only on a tick.
- R3: On a tick where the synchronised input is 1 (line above threshold), the count increases by one.
- R4: On a tick where the synchronised input is 0 (line below threshold), the count decreases by one.
- R5: `ring_det_n` is a register. It is 0 on the cycle after the count is at or above `QUAL_LEVEL` (default 48), and 1 on the cycle after the count is below it.
- R6: The count does not go below 0. After any run of low samples, a full `QUAL_LEVEL` up-ticks are needed to qualify.
- R7: The count does not rise above `CNT_MAX` (default 63). After a long high run, exactly `CNT_MAX - QUAL_LEVEL + 1` down-ticks are needed to release the output.
- R8: While `en` is 0, the count and the tick divider are cleared and `ring_det_n` is 1 from the next cycle on. After re-enable, qualification starts again from 0.
- R9: `line_above` passes through two flip-flops before the integrator uses it. A change reaches the integrator two clock cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Synchronous enable; low clears the integrator and deasserts the output |
| line_above | input | 1 | Asynchronous comparator output, 1 while the line level is above threshold |
| ring_det_n | output | 1 | Active-low qualified-ring indication |

## Verification
Two situations are hard to reach from the ports: the two saturation ends, and the exact qualification edge. No port shows the count itself. The stimulus therefore parks the input low long enough to pin the count at zero, and high long enough to pin it at the ceiling. It then checks how many ticks the output takes to change, leaving a tick of margin around the expected crossing.

Uneven square-wave bursts walk the count up gradually across several periods. A per-cycle behavioural model follows every tick, so the qualifying tick itself is compared exactly.

// File: rtl/ring_qual_pkg.sv
package ring_qual_pkg;

    // Sampled line level as seen by the integrator
    typedef enum logic {
        LVL_BELOW = 1'b0,
        LVL_ABOVE = 1'b1
    } lvl_e;

    // One integrator request per clock: step enable plus direction
    typedef struct packed {
        logic tick;
        lvl_e lvl;
    } integ_req_t;

    // Saturating single step toward the sampled level
    function automatic int unsigned sat_step(int unsigned cur, lvl_e lvl,
                                             int unsigned ceil);
        if (lvl == LVL_ABOVE)
            return (cur >= ceil) ? ceil : cur + 1;
        else
            return (cur == 0) ? 0 : cur - 1;
    endfunction

endpackage

// File: rtl/rq_sync.sv
module rq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

    assert_delay_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) == 1'b0 && $past(rst, 2) == 1'b0 |-> q == $past(d, STAGES));
endmodule

// File: rtl/rq_tick_div.sv
module rq_tick_div #(
    parameter int TICK_DIV = 4474,
    localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam logic [DIV_W-1:0] LAST = DIV_W'(TICK_DIV - 1);

    logic [DIV_W-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst || !en)       phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                  phase <= phase + 1'b1;
    end

    assign tick = en && (phase == LAST);

    assert_single_tick_R2: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
endmodule

// File: rtl/rq_integrator.sv
module rq_integrator
    import ring_qual_pkg::*;
#(
    parameter int CNT_MAX = 63,
    localparam int CNT_W = $clog2(CNT_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  integ_req_t       req,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CEIL = CNT_W'(CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst || !en)
            count <= '0;
        else if (req.tick)
            count <= CNT_W'(sat_step(int'(count), req.lvl, CNT_MAX));
    end

    assert_step_up_R3: assert property (@(posedge clk) disable iff (rst)
        en && req.tick && req.lvl == LVL_ABOVE && count != CEIL
        |=> count == $past(count) + 1'b1);
    assert_step_down_R4: assert property (@(posedge clk) disable iff (rst)
        en && req.tick && req.lvl == LVL_BELOW && count != '0
        |=> count == $past(count) - 1'b1);
    assert_floor_R6: assert property (@(posedge clk) disable iff (rst)
        count == '0 && req.lvl == LVL_BELOW |=> count == '0);
    assert_ceiling_R7: assert property (@(posedge clk) disable iff (rst)
        en && count == CEIL && req.lvl == LVL_ABOVE |=> count == CEIL);
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        en && !req.tick |=> $stable(count) || !$past(en));
endmodule

// File: rtl/ring_qual_top.sv
module ring_qual_top
    import ring_qual_pkg::*;
#(
    parameter int TICK_DIV    = 4474,
    parameter int CNT_MAX     = 63,
    parameter int QUAL_LEVEL  = 48,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W = $clog2(CNT_MAX + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic line_above,
    output logic ring_det_n
);
    localparam logic [CNT_W-1:0] QUAL = CNT_W'(QUAL_LEVEL);

    logic             lvl_sync;
    logic             tick;
    integ_req_t       req;
    logic [CNT_W-1:0] count;

    rq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(line_above), .q(lvl_sync)
    );

    rq_tick_div #(.TICK_DIV(TICK_DIV)) u_div (
        .clk(clk), .rst(rst), .en(en), .tick(tick)
    );

    always_comb begin
        req.tick = tick;
        req.lvl  = lvl_sync ? LVL_ABOVE : LVL_BELOW;
    end

    rq_integrator #(.CNT_MAX(CNT_MAX)) u_integ (
        .clk(clk), .rst(rst), .en(en), .req(req), .count(count)
    );

    always_ff @(posedge clk) begin
        if (rst || !en) ring_det_n <= 1'b1;
        else            ring_det_n <= !(count >= QUAL);
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> ring_det_n && count == '0);
    assert_qualify_R5: assert property (@(posedge clk) disable iff (rst)
        en && count >= QUAL |=> !ring_det_n);
    assert_release_R5: assert property (@(posedge clk) disable iff (rst)
        count < QUAL |=> ring_det_n);
    assert_disabled_R8: assert property (@(posedge clk) disable iff (rst)
        !en |=> ring_det_n && count == '0);
endmodule

// File: tb/ring_qual_top_bench.sv
module ring_qual_top_bench;
    localparam int D    = 8;
    localparam int CMAX = 63;
    localparam int QL   = 48;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic lvl = 1'b0;
    logic ring_det_n;

    int n_cmp = 0;
    int n_bad = 0;
    string phase = "R1";

    // behavioural reference state
    int  m_count = 0;
    int  m_div   = 0;
    bit  m_det   = 1'b1;
    bit  m_q[$];

    always #5 clk = ~clk;

    ring_qual_top #(.TICK_DIV(D), .CNT_MAX(CMAX), .QUAL_LEVEL(QL)) u_ring_qual_top (
        .clk(clk), .rst(rst), .en(en), .line_above(lvl), .ring_det_n(ring_det_n)
    );

    // reference model: every value below is computed from the pre-edge state
    always @(posedge clk) begin
        bit s2;
        bit tk;
        s2 = m_q[0];
        tk = en && (m_div == D - 1);
        if (rst || !en) m_det = 1'b1;
        else            m_det = !(m_count >= QL);
        if (rst || !en) m_count = 0;
        else if (tk) begin
            if (s2) m_count = (m_count >= CMAX) ? CMAX : m_count + 1;
            else    m_count = (m_count == 0) ? 0 : m_count - 1;
        end
        if (rst || !en) m_div = 0;
        else            m_div = (m_div == D - 1) ? 0 : m_div + 1;
        void'(m_q.pop_front());
        m_q.push_back(rst ? 1'b0 : lvl);
    end

    initial begin
        m_q.push_back(1'b0);
        m_q.push_back(1'b0);
    end

    // per-cycle comparison against the model, away from the clock edge
    always @(negedge clk) begin
        n_cmp++;
        if (ring_det_n !== m_det) begin
            n_bad++;
            $display("FAIL %s: ring_det_n actual %b expected %b at %0t",
                     phase, ring_det_n, m_det, $time);
        end
    end

    task automatic expect_det(input string req, input bit exp);
        n_cmp++;
        if (ring_det_n !== exp) begin
            n_bad++;
            $display("FAIL %s: directed ring_det_n actual %b expected %b", req, ring_det_n, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n * D) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        phase = "R1";
        repeat (4) @(negedge clk);
        expect_det("R1", 1'b1);
        rst = 1'b0; en = 1'b1;
        @(negedge clk);
        expect_det("R1", 1'b1);

        // R9/R2: settle low, count sits at floor
        phase = "R6";
        ticks(10);
        expect_det("R6", 1'b1);

        // R3/R5: sustained high; 40 ticks is short of 48, 60 is past it
        phase = "R3";
        lvl = 1'b1;
        ticks(40);
        expect_det("R3", 1'b1);
        phase = "R5";
        ticks(20);
        expect_det("R5", 1'b0);
        phase = "R7";
        ticks(30);              // pinned at ceiling
        expect_det("R7", 1'b0);

        // R4/R7: from 63, 15 low ticks keep 48, the 16th releases
        phase = "R4";
        lvl = 1'b0;
        ticks(14);
        expect_det("R7", 1'b0);
        ticks(4);
        expect_det("R4", 1'b1);

        // R6: long low run, then 47 high ticks must not qualify
        phase = "R6";
        ticks(80);
        lvl = 1'b1;
        ticks(46);
        expect_det("R6", 1'b1);
        ticks(4);
        expect_det("R6", 1'b0);

        // R8: disable while qualified
        phase = "R8";
        @(negedge clk); en = 1'b0;
        @(negedge clk);
        expect_det("R8", 1'b1);
        ticks(3);
        expect_det("R8", 1'b1);
        en = 1'b1;
        ticks(40);
        expect_det("R8", 1'b1);
        ticks(12);
        expect_det("R8", 1'b0);

        // square-wave bursts, 26 high / 14 low ticks (40-tick period)
        phase = "R4";
        lvl = 1'b0;
        ticks(70);
        phase = "R3";
        for (int p = 0; p < 4; p++) begin
            lvl = 1'b1; ticks(26);
            lvl = 1'b0; ticks(14);
        end
        // symmetric bursts: net zero, from floor never reaches 48
        phase = "R6";
        ticks(70);
        for (int p = 0; p < 3; p++) begin
            lvl = 1'b1; ticks(20);
            expect_det("R6", 1'b1);
            lvl = 1'b0; ticks(20);
        end

        // R9: a pulse shorter than a tick period may or may not land; model tracks it
        phase = "R9";
        for (int k = 0; k < 20; k++) begin
            @(negedge clk); lvl = 1'b1;
            repeat (3) @(negedge clk);
            lvl = 1'b0;
            repeat (5 + k % 3) @(negedge clk);
        end

        // R1: reset in the middle of a qualified ring
        phase = "R1";
        lvl = 1'b1;
        ticks(60);
        expect_det("R1", 1'b0);
        rst = 1'b1;
        @(negedge clk);
        expect_det("R1", 1'b1);
        rst = 1'b0;
        ticks(40);
        expect_det("R1", 1'b1);

        ticks(2);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule